// File: doc/BRIEF.md
# GPIO Controller with Both-Edge Change Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 lines, with the line count set by a parameter. Software picks the direction of each line, sets the output levels and reads back the level of every line through a simple 32-bit register port. The port has a byte address, one-cycle write and read strobes, write data and registered read data.

Every line is sampled through a synchroniser, and any level change, rising or falling, sets a sticky flag in a change-status register. Software clears a flag by writing a 1 to it. A per-line enable mask gates the flags, and the OR of the enabled flags drives a single interrupt line to a parent interrupt controller. A write-mask register limits which output bits a data write may change. A read-only type register reports that every line senses both edges.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction, output data, interrupt enable and change status are all zero. Every line is an input (`pin_oe` = 0), `pin_out` is 0, `irq` is low, and the write mask (offset 0x10) reads all ones on the implemented lines.
- R2: Offset 0x00 holds the direction. A 1 in bit i makes line i an output and drives `pin_oe[i]` high from the cycle after the write. A 0 makes it an input.
- R3: A write to offset 0x04 sets the output levels on `pin_out`. A read of 0x04 returns, for each line, the driven level if the line is an output and the synchronised `pin_in` level if it is an input.
- R4: A data write changes only the bits where the write mask (offset 0x10) is 1. Bits where the mask is 0 keep their previous output level.
- R5: A rising or a falling edge on `pin_in[i]` sets bit i of the change register (offset 0x0C) on the third rising clock edge after the pin changes.
- R6: Writing to offset 0x0C clears each change bit written with 1 and leaves each bit written with 0 unchanged.
- R7: `irq` is high exactly while some line has both its change bit and its enable bit (offset 0x08, 1 = unmasked) set. A change on a masked line sets its change bit but does not raise `irq`.
- R8: If a new edge and a write-1 clear hit the same change bit in the same cycle, the bit stays set.
- R9: Offset 0x14 is read-only and returns 1 on every implemented line to report both-edge sensing. Writes to it have no effect.
- R10: Register bits at and above NUM_LINES read as 0 and ignore writes. Reads of an offset outside 0x00 to 0x14 return 0.
- R11: `bus_rdata` takes the selected register value on the clock edge where `bus_rd` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_LINES | Pad input levels, asynchronous |
| pin_out | output | NUM_LINES | Output levels |
| pin_oe | output | NUM_LINES | Output enables, 1 = drive |
| irq | output | 1 | Combined change interrupt |

## Verification
The assertions assume that `pin_in` is low throughout reset. A pin held high during reset would look like a rising edge once the synchroniser fills, and the change-flag properties would then see a flag they did not expect. They also assume that `bus_wr` and `bus_rd` are never high in the same cycle and that each strobe lasts one cycle. The bench changes pins and bus signals only on falling clock edges, holds every pin low until reset is released, and issues each access as a single-cycle strobe. The edge-against-clear case is timed so that the clear lands on the exact edge where the synchronised change reaches the status register.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    // Register offsets; software decodes these
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CHG   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_WMASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h14;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] ien;
        logic [REG_W-1:0] chg;
        logic [REG_W-1:0] wmask;
        logic [REG_W-1:0] rdata;
    } gpio_regs_t;

    function automatic logic [REG_W-1:0] line_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] edge_o
);
    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // Any difference from the previous sample is an edge, either polarity
    assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [REG_W-1:0]     wdata_i,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic [NUM_LINES-1:0] edge_i,
    output logic [NUM_LINES-1:0] dir_o,
    output logic [NUM_LINES-1:0] dout_o,
    output logic [NUM_LINES-1:0] ien_o,
    output logic [NUM_LINES-1:0] chg_o,
    output logic [NUM_LINES-1:0] wmask_o,
    output logic [REG_W-1:0]     rdata_o
);
    localparam logic [REG_W-1:0] LMASK = line_mask(NUM_LINES);

    gpio_regs_t r_d;
    gpio_regs_t r_q;
    logic [REG_W-1:0] level_w;
    logic [REG_W-1:0] edge_w;
    logic [REG_W-1:0] clr_w;

    always_comb begin
        level_w = '0;
        edge_w  = '0;
        level_w[NUM_LINES-1:0] = level_i;
        edge_w[NUM_LINES-1:0]  = edge_i;
        clr_w = '0;
        r_d   = r_q;

        if (wr_i) begin
            case (addr_i)
                OFS_DIR:   r_d.dir   = wdata_i & LMASK;
                OFS_DATA:  r_d.dout  = ((r_q.dout & ~r_q.wmask) |
                                        (wdata_i & r_q.wmask)) & LMASK;
                OFS_IEN:   r_d.ien   = wdata_i & LMASK;
                OFS_CHG:   clr_w     = wdata_i;
                OFS_WMASK: r_d.wmask = wdata_i & LMASK;
                default:   ;
            endcase
        end

        // New edge has priority over a clear of the same bit
        r_d.chg = ((r_q.chg & ~clr_w) | edge_w) & LMASK;

        if (rd_i) begin
            case (addr_i)
                OFS_DIR:   r_d.rdata = r_q.dir;
                OFS_DATA:  r_d.rdata = ((r_q.dir & r_q.dout) |
                                        (~r_q.dir & level_w)) & LMASK;
                OFS_IEN:   r_d.rdata = r_q.ien;
                OFS_CHG:   r_d.rdata = r_q.chg;
                OFS_WMASK: r_d.rdata = r_q.wmask;
                OFS_TYPE:  r_d.rdata = LMASK;
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.wmask <= LMASK;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir_o   = r_q.dir[NUM_LINES-1:0];
    assign dout_o  = r_q.dout[NUM_LINES-1:0];
    assign ien_o   = r_q.ien[NUM_LINES-1:0];
    assign chg_o   = r_q.chg[NUM_LINES-1:0];
    assign wmask_o = r_q.wmask[NUM_LINES-1:0];
    assign rdata_o = r_q.rdata;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq
);
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] dout_q;
    logic [NUM_LINES-1:0] ien_q;
    logic [NUM_LINES-1:0] chg_q;
    logic [NUM_LINES-1:0] wmask_q;

    gpio_edge_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_lvl)
    );

    gpio_edge_det #(
        .WIDTH (NUM_LINES)
    ) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_lvl),
        .edge_o  (edge_vec)
    );

    gpio_edge_regs #(
        .NUM_LINES (NUM_LINES)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .level_i (sync_lvl),
        .edge_i  (edge_vec),
        .dir_o   (dir_q),
        .dout_o  (dout_q),
        .ien_o   (ien_q),
        .chg_o   (chg_q),
        .wmask_o (wmask_q),
        .rdata_o (bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = dout_q;
    assign irq     = |(chg_q & ien_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic                 irq,
    input logic [NUM_LINES-1:0] edge_vec,
    input logic [NUM_LINES-1:0] chg_q,
    input logic [NUM_LINES-1:0] ien_q,
    input logic [NUM_LINES-1:0] wmask_q
);
    localparam logic [31:0] LMASK = line_mask(NUM_LINES);

    // R2
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata[NUM_LINES-1:0]));

    // R4
    a_r4_data_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |=>
        pin_out == (($past(pin_out) & ~$past(wmask_q)) |
                    ($past(bus_wdata[NUM_LINES-1:0]) & $past(wmask_q))));

    // R5 and R8: every detected edge leaves its change bit set
    a_r5_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_vec) |=> ((chg_q & $past(edge_vec)) == $past(edge_vec)));

    // R6
    a_r6_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CHG) |=>
        ((chg_q & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(edge_vec)) == '0));

    // R7
    a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(chg_q & ien_q)));

    // R10
    a_r10_upper_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LMASK) == 32'd0);

    // R11
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NUM_LINES (NUM_LINES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .edge_vec  (edge_vec),
    .chg_q     (chg_q),
    .ien_q     (ien_q),
    .wmask_q   (wmask_q)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
    localparam int N = 8;
    localparam logic [7:0] A_DIR = 8'h00, A_DATA = 8'h04, A_IEN = 8'h08,
                           A_CHG = 8'h0C, A_WMASK = 8'h10, A_TYPE = 8'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    gpio_edge_ctrl #(.NUM_LINES(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        bus_read(A_DIR, v);   chk("R1 dir", v, 32'h0);
        bus_read(A_WMASK, v); chk("R1 wmask", v, 32'hFF);
        bus_read(A_CHG, v);   chk("R1 chg", v, 32'h0);
        bus_read(A_IEN, v);   chk("R1 ien", v, 32'h0);
    endtask

    task automatic t_dir;
        logic [31:0] v;
        bus_write(A_DIR, 32'hA5);
        chk("R2 pin_oe", 32'(pin_oe), 32'hA5);
        bus_read(A_DIR, v); chk("R2 dir readback", v, 32'hA5);
        bus_write(A_DIR, 32'h0);
        chk("R2 pin_oe cleared", 32'(pin_oe), 32'h0);
    endtask

    task automatic t_data_io;
        logic [31:0] v;
        bus_write(A_DATA, 32'h33);
        chk("R3 pin_out", 32'(pin_out), 32'h33);
        bus_write(A_DIR, 32'hF0);
        @(negedge clk) pin_in = 8'h05;
        idle(3);
        bus_read(A_DATA, v); chk("R3 mixed level", v, 32'h35);
        @(negedge clk) pin_in = 8'h00;
        idle(3);
        bus_write(A_CHG, 32'hFF);
        bus_write(A_DIR, 32'h0);
    endtask

    task automatic t_wmask;
        logic [31:0] v;
        bus_write(A_DATA, 32'h3C);
        chk("R4 full mask", 32'(pin_out), 32'h3C);
        bus_write(A_WMASK, 32'h0F);
        bus_read(A_WMASK, v); chk("R4 mask readback", v, 32'h0F);
        bus_write(A_DATA, 32'hC3);
        chk("R4 partial mask", 32'(pin_out), 32'h33);
        bus_write(A_WMASK, 32'hFF);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        bus_write(A_IEN, 32'h02);
        @(negedge clk) pin_in = 8'h02;
        idle(2);
        chk("R5 rise latency not yet", 32'(irq), 32'h0);
        idle(1);
        chk("R5 R7 rise irq", 32'(irq), 32'h1);
        bus_read(A_CHG, v); chk("R5 rise flag", v, 32'h02);
        bus_write(A_CHG, 32'h00);
        bus_read(A_CHG, v); chk("R6 zero write keeps", v, 32'h02);
        bus_write(A_CHG, 32'h02);
        chk("R6 clear drops irq", 32'(irq), 32'h0);
        bus_read(A_CHG, v); chk("R6 flag cleared", v, 32'h0);
        @(negedge clk) pin_in = 8'h00;
        idle(3);
        chk("R5 fall irq", 32'(irq), 32'h1);
        bus_write(A_CHG, 32'h02);
        @(negedge clk) pin_in = 8'h04;
        idle(3);
        chk("R7 masked line quiet", 32'(irq), 32'h0);
        bus_read(A_CHG, v); chk("R7 masked flag set", v, 32'h04);
        bus_write(A_IEN, 32'h04);
        chk("R7 unmask raises", 32'(irq), 32'h1);
        bus_write(A_IEN, 32'h00);
        chk("R7 mask lowers", 32'(irq), 32'h0);
        @(negedge clk) pin_in = 8'h00;
        idle(3);
        bus_write(A_CHG, 32'hFF);
    endtask

    task automatic t_race;
        logic [31:0] v;
        @(negedge clk) pin_in = 8'h01;
        idle(3);
        @(negedge clk) pin_in = 8'h00;
        idle(2);
        addr = A_CHG; wdata = 32'h01; wr = 1'b1;
        @(negedge clk) wr = 1'b0;
        bus_read(A_CHG, v); chk("R8 edge beats clear", v, 32'h01);
        bus_write(A_CHG, 32'h01);
        bus_read(A_CHG, v); chk("R6 plain clear", v, 32'h0);
    endtask

    task automatic t_type;
        logic [31:0] v;
        bus_read(A_TYPE, v); chk("R9 type", v, 32'hFF);
        bus_write(A_TYPE, 32'h0);
        bus_read(A_TYPE, v); chk("R9 type after write", v, 32'hFF);
    endtask

    task automatic t_upper;
        logic [31:0] v;
        bus_write(A_DIR, 32'hFFFF_FFFF);
        bus_read(A_DIR, v); chk("R10 dir upper", v, 32'hFF);
        bus_write(A_DIR, 32'h0);
        bus_write(A_WMASK, 32'hFFFF_0000);
        bus_read(A_WMASK, v); chk("R10 wmask upper", v, 32'h0);
        bus_write(A_WMASK, 32'hFF);
        bus_read(8'h18, v); chk("R10 unmapped", v, 32'h0);
    endtask

    task automatic t_rdata_hold;
        logic [31:0] v;
        bus_write(A_DIR, 32'h3C);
        bus_read(A_DIR, v); chk("R11 read", v, 32'h3C);
        bus_write(A_DIR, 32'h5A);
        idle(3);
        chk("R11 held", rdata, 32'h3C);
        bus_write(A_DIR, 32'h0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_dir();
        t_data_io();
        t_wmask();
        t_edges();
        t_race();
        t_type();
        t_upper();
        t_rdata_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog R11 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule